// File: doc/BRIEF.md
# Coarse-Quantized Complex Cross-Correlation Array

This block is a two-dimensional grid of complex multiply-accumulate cells. A row bus carries one group of complex signals and a column bus carries a second group; each valid cycle, every cell multiplies its row sample by the conjugate of its column sample and adds the result into a private complex accumulator. One cycle of valid input therefore produces one product for every row/column pairing.

The samples are coarse. Each real and each imaginary part is a 2-bit code for one of four odd levels, so the multipliers are tiny and the accumulators set the cost of the array. To cover far more signal pairs than the grid has cells, the surrounding logic presents successive group pairings over time. The array then runs at its cell clock divided by the number of pairings it is reused for.

An integrate strobe closes the current period. In one cycle it copies every cell's total into a readout chain and restarts the accumulators from zero. The chain then streams the totals out one per cycle while the next period accumulates without a gap. A select input chooses whether the cells take samples from a direct input bus or from the bus that a sample buffer would drive, so the buffer can be skipped.

Top module: `qcorr_array`

## Requirements
- R1: A 2-bit code {sign,mag} means (mag ? 3 : 1) times (sign ? -1 : +1), so 00=+1, 01=+3, 10=-1, 11=-3. Sample k of a bus sits in bits [4k+3:4k], with the real code in [4k+3:4k+2] and the imaginary code in [4k+1:4k]. On each accepted cycle the cell adds re = xr·yr + xi·yi and im = xi·yr − xr·yi, where x is its row sample and y is its column sample.
- R2: Cell (i,j) pairs row sample i with column sample j. Its result is read out at position i·COLS + j, so the readout is in row-major order.
- R3: Each accumulator part saturates at the signed ACC_W-bit limits instead of wrapping. A per-cell overflow flag is set when either part clips, and it stays set until the end of the period.
- R4: When integrate is high, any sample accepted in that same cycle belongs to the closing period. All accumulators and overflow flags then restart from zero.
- R5: The cycle after integrate, rdValid rises and rdData presents cell 0. One cell follows per cycle. rdData holds the real part in its upper ACC_W bits and the imaginary part in its lower ACC_W bits, and rdOvf carries that cell's flag.
- R6: rdDone is a one-cycle pulse in the cycle that follows the last cell's output. rdValid is low during that pulse.
- R7: Samples accepted while a readout is in progress are added to the new period. None is lost.
- R8: With bypassSel=1 the cells take directRow, directCol and directValid, and the memory-side bus is ignored. With bypassSel=0 they take memRow, memCol and memValid, and the direct bus is ignored.
- R9: After reset, and whenever no readout is running, rdValid, rdDone, rdData and rdOvf are all zero.
- R10: A cycle whose selected valid is low leaves every accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bypassSel | input | 1 | 1 selects the direct bus, 0 selects the memory bus |
| directRow | input | 4*ROWS | Direct row samples |
| directCol | input | 4*COLS | Direct column samples |
| directValid | input | 1 | Direct samples are valid |
| memRow | input | 4*ROWS | Row samples from the buffer side |
| memCol | input | 4*COLS | Column samples from the buffer side |
| memValid | input | 1 | Buffer-side samples are valid |
| integrate | input | 1 | Ends the period and starts a readout |
| rdValid | output | 1 | Readout word present |
| rdData | output | 2*ACC_W | {real, imaginary} of the current cell |
| rdOvf | output | 1 | Overflow flag of the current cell |
| rdDone | output | 1 | Pulse after the last cell |

## Verification
The bench builds a 3-row by 2-column grid with 8-bit accumulators. The non-square shape catches any swap of row and column index in the row-major readout. With accumulators that narrow, ten full-scale samples drive cells past both the positive and the negative limit, so clipping and the sticky flag are reached in a few cycles. A period that closes on a cycle carrying a sample, followed by a readout during which fresh samples arrive, exercises the boundary between periods.

// File: rtl/qcorr_pkg.sv
package qcorr_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic accEn;    // selected sample is valid this cycle
    logic capture;  // close period: load chain, clear accumulators
    logic shift;    // advance readout chain by one cell
  } qc_ctrl_t;

  // 2-bit code {sign,mag} to signed level, 7 bits wide for product headroom
  function automatic logic signed [6:0] codeLevel(input logic [1:0] code);
    logic signed [6:0] mag;
    mag = code[0] ? 7'sd3 : 7'sd1;
    return code[1] ? -mag : mag;
  endfunction

endpackage

// File: rtl/qcorr_cell.sv
module qcorr_cell
  import qcorr_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [3:0]              xSample,
  input  logic [3:0]              ySample,
  input  qc_ctrl_t                ctrl,
  output logic signed [ACC_W-1:0] nextRe,
  output logic signed [ACC_W-1:0] nextIm,
  output logic                    nextOvf
);
  localparam int SUM_W = ACC_W + 1;
  localparam int PROD_W = 7;
  localparam logic signed [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] accRe, accIm;
  logic                    accOvf;
  logic signed [PROD_W-1:0] xr, xi, yr, yi, prodRe, prodIm;
  logic signed [SUM_W-1:0]  sumRe, sumIm;
  logic signed [ACC_W-1:0]  satRe, satIm;
  logic                     clipRe, clipIm;

  always_comb begin
    xr = codeLevel(xSample[3:2]);
    xi = codeLevel(xSample[1:0]);
    yr = codeLevel(ySample[3:2]);
    yi = codeLevel(ySample[1:0]);
    prodRe = xr * yr + xi * yi;
    prodIm = xi * yr - xr * yi;
    sumRe = $signed({accRe[ACC_W-1], accRe})
          + $signed({{(SUM_W-PROD_W){prodRe[PROD_W-1]}}, prodRe});
    sumIm = $signed({accIm[ACC_W-1], accIm})
          + $signed({{(SUM_W-PROD_W){prodIm[PROD_W-1]}}, prodIm});
    clipRe = sumRe[SUM_W-1] ^ sumRe[SUM_W-2];
    clipIm = sumIm[SUM_W-1] ^ sumIm[SUM_W-2];
    satRe = clipRe ? (sumRe[SUM_W-1] ? NEG_LIM : POS_LIM) : sumRe[ACC_W-1:0];
    satIm = clipIm ? (sumIm[SUM_W-1] ? NEG_LIM : POS_LIM) : sumIm[ACC_W-1:0];
    nextRe  = ctrl.accEn ? satRe : accRe;
    nextIm  = ctrl.accEn ? satIm : accIm;
    nextOvf = accOvf | (ctrl.accEn & (clipRe | clipIm));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accRe  <= '0;
      accIm  <= '0;
      accOvf <= 1'b0;
    end else if (ctrl.capture) begin
      accRe  <= '0;
      accIm  <= '0;
      accOvf <= 1'b0;
    end else if (ctrl.accEn) begin
      accRe  <= nextRe;
      accIm  <= nextIm;
      accOvf <= nextOvf;
    end
  end

endmodule

// File: rtl/qcorr_ctrl.sv
module qcorr_ctrl
  import qcorr_pkg::*;
#(
  parameter int NCELL = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bypassSel,
  input  logic     directValid,
  input  logic     memValid,
  input  logic     integrate,
  output qc_ctrl_t ctrl,
  output logic     rdValid,
  output logic     rdDone
);
  localparam int CNT_W = (NCELL > 1) ? $clog2(NCELL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NCELL - 1);

  logic             busy;
  logic [CNT_W-1:0] cellCnt;
  logic             doneQ;

  always_comb begin
    ctrl.accEn   = bypassSel ? directValid : memValid;
    ctrl.capture = integrate;
    ctrl.shift   = busy & ~integrate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cellCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (integrate) begin
        busy    <= 1'b1;
        cellCnt <= '0;
      end else if (busy) begin
        if (cellCnt == LAST) begin
          busy  <= 1'b0;
          doneQ <= 1'b1;
        end
        cellCnt <= cellCnt + 1'b1;
      end
    end
  end

  assign rdValid = busy;
  assign rdDone  = doneQ;

endmodule

// File: rtl/qcorr_datapath.sv
module qcorr_datapath
  import qcorr_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int ACC_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bypassSel,
  input  logic [4*ROWS-1:0]    directRow,
  input  logic [4*COLS-1:0]    directCol,
  input  logic [4*ROWS-1:0]    memRow,
  input  logic [4*COLS-1:0]    memCol,
  input  qc_ctrl_t             ctrl,
  output logic [2*ACC_W-1:0]   rdData,
  output logic                 rdOvf
);
  localparam int NCELL = ROWS * COLS;
  localparam int WORD_W = 2 * ACC_W + 1;

  logic [4*ROWS-1:0] rowSel;
  logic [4*COLS-1:0] colSel;
  logic [WORD_W-1:0] capWord [NCELL];
  logic [WORD_W-1:0] chain   [NCELL];

  assign rowSel = bypassSel ? directRow : memRow;
  assign colSel = bypassSel ? directCol : memCol;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic signed [ACC_W-1:0] cRe, cIm;
      logic                    cOvf;
      qcorr_cell #(.ACC_W(ACC_W)) u_cell (
        .clk     (clk),
        .rstN    (rstN),
        .xSample (rowSel[4*r +: 4]),
        .ySample (colSel[4*c +: 4]),
        .ctrl    (ctrl),
        .nextRe  (cRe),
        .nextIm  (cIm),
        .nextOvf (cOvf)
      );
      assign capWord[r*COLS + c] = {cOvf, cRe, cIm};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NCELL; k++) chain[k] <= '0;
    end else if (ctrl.capture) begin
      for (int k = 0; k < NCELL; k++) chain[k] <= capWord[k];
    end else if (ctrl.shift) begin
      for (int k = 0; k < NCELL - 1; k++) chain[k] <= chain[k+1];
      chain[NCELL-1] <= '0;
    end
  end

  assign rdOvf  = chain[0][WORD_W-1];
  assign rdData = chain[0][2*ACC_W-1:0];

endmodule

// File: rtl/qcorr_array.sv
module qcorr_array
  import qcorr_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int ACC_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bypassSel,
  input  logic [4*ROWS-1:0]  directRow,
  input  logic [4*COLS-1:0]  directCol,
  input  logic               directValid,
  input  logic [4*ROWS-1:0]  memRow,
  input  logic [4*COLS-1:0]  memCol,
  input  logic               memValid,
  input  logic               integrate,
  output logic               rdValid,
  output logic [2*ACC_W-1:0] rdData,
  output logic               rdOvf,
  output logic               rdDone
);
  localparam int NCELL = ROWS * COLS;

  qc_ctrl_t ctrl;

  qcorr_ctrl #(.NCELL(NCELL)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bypassSel   (bypassSel),
    .directValid (directValid),
    .memValid    (memValid),
    .integrate   (integrate),
    .ctrl        (ctrl),
    .rdValid     (rdValid),
    .rdDone      (rdDone)
  );

  qcorr_datapath #(.ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bypassSel (bypassSel),
    .directRow (directRow),
    .directCol (directCol),
    .memRow    (memRow),
    .memCol    (memCol),
    .ctrl      (ctrl),
    .rdData    (rdData),
    .rdOvf     (rdOvf)
  );

endmodule

// File: rtl/qcorr_array_chk.sv
module qcorr_array_chk #(
  parameter int ACC_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               integrate,
  input logic               rdValid,
  input logic [2*ACC_W-1:0] rdData,
  input logic               rdOvf,
  input logic               rdDone
);

  AST_FIRST_AFTER_INTEGRATE: assert property (@(posedge clk) disable iff (!rstN)
    integrate |=> rdValid); // R5

  AST_READOUT_NEEDS_INTEGRATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(integrate)); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> (!rdValid && $past(rdValid))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0 && !rdOvf)); // R9

endmodule

bind qcorr_array qcorr_array_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .integrate (integrate),
  .rdValid   (rdValid),
  .rdData    (rdData),
  .rdOvf     (rdOvf),
  .rdDone    (rdDone)
);

// File: tb/qcorr_array_bench.sv
module qcorr_array_bench;
  localparam int ROWS = 3;
  localparam int COLS = 2;
  localparam int AW   = 8;
  localparam int NC   = ROWS * COLS;
  localparam int PMAX = 2 ** (AW - 1) - 1;
  localparam int PMIN = -(2 ** (AW - 1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bypassSel = 1'b1;
  logic [4*ROWS-1:0] directRow = '0, memRow = '0;
  logic [4*COLS-1:0] directCol = '0, memCol = '0;
  logic directValid = 1'b0, memValid = 1'b0, integrate = 1'b0;
  logic rdValid, rdOvf, rdDone;
  logic [2*AW-1:0] rdData;

  qcorr_array #(.ROWS(ROWS), .COLS(COLS), .ACC_W(AW)) u_qcorr_array (
    .clk(clk), .rstN(rstN), .bypassSel(bypassSel),
    .directRow(directRow), .directCol(directCol), .directValid(directValid),
    .memRow(memRow), .memCol(memCol), .memValid(memValid),
    .integrate(integrate), .rdValid(rdValid), .rdData(rdData),
    .rdOvf(rdOvf), .rdDone(rdDone)
  );

  always #10 clk = ~clk;

  int nChk = 0, nBad = 0;
  int accR[NC], accI[NC], accO[NC], snapR[NC], snapI[NC], snapO[NC];
  logic obsValid, obsOvf, obsDone;
  logic [2*AW-1:0] obsData;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int lv(input logic [1:0] c);
    int m;
    m = c[0] ? 3 : 1;
    return c[1] ? -m : m;
  endfunction

  function automatic int clampV(input int v);
    if (v > PMAX) return PMAX;
    if (v < PMIN) return PMIN;
    return v;
  endfunction

  task automatic modelAdd(input logic [4*ROWS-1:0] rv, input logic [4*COLS-1:0] cv);
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) begin
        int xr, xi, yr, yi, sr, si, k;
        k  = i * COLS + j;
        xr = lv(rv[4*i+2 +: 2]); xi = lv(rv[4*i +: 2]);
        yr = lv(cv[4*j+2 +: 2]); yi = lv(cv[4*j +: 2]);
        sr = accR[k] + xr * yr + xi * yi;
        si = accI[k] + xi * yr - xr * yi;
        if (sr != clampV(sr) || si != clampV(si)) accO[k] = 1;
        accR[k] = clampV(sr);
        accI[k] = clampV(si);
      end
  endtask

  task automatic modelClear();
    for (int k = 0; k < NC; k++) begin accR[k] = 0; accI[k] = 0; accO[k] = 0; end
  endtask

  // one clock: sample outputs at negedge, drive inputs, update model, wait edge
  task automatic runCycle(input logic byp,
                          input logic [4*ROWS-1:0] dR, input logic [4*COLS-1:0] dC, input logic dV,
                          input logic [4*ROWS-1:0] mR, input logic [4*COLS-1:0] mC, input logic mV,
                          input logic integ);
    @(negedge clk);
    obsValid = rdValid; obsData = rdData; obsOvf = rdOvf; obsDone = rdDone;
    bypassSel = byp; directRow = dR; directCol = dC; directValid = dV;
    memRow = mR; memCol = mC; memValid = mV; integrate = integ;
    if (byp ? dV : mV) modelAdd(byp ? dR : mR, byp ? dC : mC);
    if (integ) begin
      for (int k = 0; k < NC; k++) begin snapR[k] = accR[k]; snapI[k] = accI[k]; snapO[k] = accO[k]; end
      modelClear();
    end
    @(posedge clk);
  endtask

  task automatic idleCycle();
    runCycle(1'b1, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  // stream out a readout; optionally feed random direct samples meanwhile
  task automatic readOut(input string tag, input bit feed);
    for (int k = 0; k <= NC; k++) begin
      logic [4*ROWS-1:0] r;
      logic [4*COLS-1:0] c;
      r = (4*ROWS)'($urandom); c = (4*COLS)'($urandom);
      runCycle(1'b1, r, c, feed, '0, '0, 1'b0, 1'b0);
      if (k < NC) begin
        chk(obsValid === 1'b1, {tag, " R5 valid"}, int'(obsValid), 1);
        chk(obsDone === 1'b0, {tag, " R6 early done"}, int'(obsDone), 0);
        chk(int'($signed(obsData[2*AW-1:AW])) == snapR[k], {tag, " R1 R2 real"},
            int'($signed(obsData[2*AW-1:AW])), snapR[k]);
        chk(int'($signed(obsData[AW-1:0])) == snapI[k], {tag, " R1 R2 imag"},
            int'($signed(obsData[AW-1:0])), snapI[k]);
        chk(int'(obsOvf) == snapO[k], {tag, " R3 ovf"}, int'(obsOvf), snapO[k]);
      end else begin
        chk(obsDone === 1'b1 && obsValid === 1'b0, {tag, " R6 done pulse"}, int'(obsDone), 1);
      end
    end
    if (!feed) begin
      idleCycle();
      chk(obsDone === 1'b0 && obsValid === 1'b0 && obsData == '0, {tag, " R9 idle"},
          int'(obsData), 0);
    end
  endtask

  task automatic t_reset();
    idleCycle();
    chk(obsValid === 1'b0 && obsDone === 1'b0, "R9 reset strobes", int'(obsValid), 0);
    chk(obsData == '0 && obsOvf === 1'b0, "R9 reset data", int'(obsData), 0);
  endtask

  task automatic t_random();  // direct bus, gaps, memory bus toggling as noise
    for (int n = 0; n < 9; n++) begin
      logic v;
      v = (n % 2 == 0);  // invalid cycles carry data too (R10)
      runCycle(1'b1, (4*ROWS)'($urandom), (4*COLS)'($urandom), v,
               (4*ROWS)'($urandom), (4*COLS)'($urandom), 1'b1, 1'b0);
    end
    runCycle(1'b1, '0, '0, 1'b0, '1, '1, 1'b1, 1'b1);
    readOut("random R8 R10", 1'b0);
  endtask

  task automatic t_memPath();  // bypassSel=0, direct bus is noise (R8)
    for (int n = 0; n < 5; n++)
      runCycle(1'b0, (4*ROWS)'($urandom), (4*COLS)'($urandom), 1'b1,
               (4*ROWS)'($urandom), (4*COLS)'($urandom), 1'b1, 1'b0);
    runCycle(1'b0, '1, '1, 1'b1, '0, '0, 1'b0, 1'b1);
    readOut("mempath R8", 1'b0);
  endtask

  task automatic t_saturate();  // full scale, drives both limits (R3)
    logic [4*ROWS-1:0] r;
    logic [4*COLS-1:0] c;
    r = {4'b0101, 4'b0111, 4'b1111};  // row2 +3+3j, row1 +3-3j, row0 -3-3j
    c = {4'b0101, 4'b0101};
    for (int n = 0; n < 10; n++) runCycle(1'b1, r, c, 1'b1, '0, '0, 1'b0, 1'b0);
    runCycle(1'b1, '0, '0, 1'b0, '0, '0, 1'b0, 1'b1);
    chk(snapR[0] == PMIN && snapR[4] == PMAX && snapO[2] == 1, "R3 model sanity", snapR[0], PMIN);
    readOut("saturate R3", 1'b0);
  endtask

  task automatic t_overlap();  // closing sample + samples during readout (R4 R7)
    for (int n = 0; n < 4; n++)
      runCycle(1'b1, (4*ROWS)'($urandom), (4*COLS)'($urandom), 1'b1, '0, '0, 1'b0, 1'b0);
    runCycle(1'b1, (4*ROWS)'($urandom), (4*COLS)'($urandom), 1'b1, '0, '0, 1'b0, 1'b1);
    readOut("closing R4", 1'b1);
    runCycle(1'b1, (4*ROWS)'($urandom), (4*COLS)'($urandom), 1'b1, '0, '0, 1'b0, 1'b0);
    runCycle(1'b1, '0, '0, 1'b0, '0, '0, 1'b0, 1'b1);
    readOut("overlap R7 R4", 1'b0);
  endtask

  initial begin
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_random();
    t_memPath();
    t_saturate();
    t_overlap();
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #2_000_000;
    nChk++; nBad++;
    $display("FAIL R6 watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule